// File: doc/BRIEF.md
# Serial Transmitter with Clear-to-Send Gating

This block turns 8-bit characters into asynchronous serial frames on a single output line. The line rests high. Each frame has one low start bit, then eight data bits sent least significant bit first, then one high stop bit. There is no parity bit. Two inputs set the bit period: an oversampling field and a baud divisor. One bit lasts (oversampling field + 1) × divisor clock cycles. For example, with a 48 MHz clock, an oversampling field of 15 and a divisor of 3 give 1,000,000 baud.

A single holding register takes characters through a valid/ready handshake, so the next character can wait while the current frame is on the line. A clear-to-send input, active low, can be used to hold back transmission. It passes through a two-flop synchroniser. When gating is enabled, this input is examined only when a new frame is about to begin. While it is deasserted, the line stays at mark and the pending character waits. A frame that has already started always finishes unchanged. A done flag reports that the last stop bit has ended and nothing is waiting to be sent.

Top module: `uart_cts_tx`

## Requirements
- R1: One bit period lasts exactly (osr_i+1) × sbr_i clock cycles (a divisor of 0 behaves as 1). With osr_i=15 and sbr_i=3, a start bit lasts 48 cycles.
- R2: A frame is one low start bit, then data bits 0 through 7 in that order (least significant bit first), then one high stop bit. txd_o is high whenever no frame is being sent.
- R3: tx_ready_o is high exactly when the holding register is empty. A character is taken in on a cycle where tx_valid_i and tx_ready_o are both high, and tx_ready_o is low on the next cycle.
- R4: When cts_en_i=1 and the synchronised cts_ni is high (deasserted), no new frame starts, txd_o stays high, and the held character is kept. It is sent once cts_ni goes low.
- R5: A change of cts_ni while a frame is being shifted out does not shorten, pause or alter that frame.
- R6: When cts_en_i=0, characters are sent whatever the level of cts_ni.
- R7: tx_done_o is 1 after reset. It goes to 0 on the cycle after a character is accepted. It goes back to 1 when a stop bit ends with no character waiting. While tx_done_o is 1, txd_o is high.
- R8: After reset, txd_o=1, tx_ready_o=1 and tx_done_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osr_i | input | 5 | Oversampling field; the ratio is osr_i+1 |
| sbr_i | input | 13 | Baud divisor |
| cts_en_i | input | 1 | Enables clear-to-send gating |
| cts_ni | input | 1 | Clear-to-send, active low, asynchronous |
| tx_data_i | input | 8 | Character to send |
| tx_valid_i | input | 1 | Character valid |
| tx_ready_o | output | 1 | Holding register empty |
| txd_o | output | 1 | Serial data line, idles high |
| tx_done_o | output | 1 | Last stop bit finished and nothing waiting |

## Verification
The hardest case to reach is a clear-to-send change that lands in the middle of a frame, while a second character is already waiting in the holding register. The bench waits for the falling edge of the start bit and lets three bit periods pass. It then deasserts cts_ni and pushes the second character. The decoder must see the first frame arrive intact, and txd_o must then stay at mark until cts_ni is released. Start-bit lengths are measured at the port with a low-run counter, using a character whose bit 0 is 1 so the start bit cannot merge with the first data bit.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int unsigned CHAR_W = 8;
  localparam int unsigned IDX_W  = $clog2(CHAR_W);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } tx_state_e;
endpackage

// File: rtl/uart_tx_baud_gen.sv
module uart_tx_baud_gen #(
  parameter int unsigned OSR_W = 5,
  parameter int unsigned SBR_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [OSR_W-1:0] osr_i,
  input  logic [SBR_W-1:0] sbr_i,
  output logic             bit_tick_o
);
  logic [SBR_W-1:0] sbr_eff, sbr_cnt_q;
  logic [OSR_W-1:0] osr_cnt_q;
  logic             sbr_last, osr_last;

  assign sbr_eff    = (sbr_i == '0) ? SBR_W'(1) : sbr_i;
  assign sbr_last   = (sbr_cnt_q == sbr_eff - SBR_W'(1));
  assign osr_last   = (osr_cnt_q == osr_i);
  assign bit_tick_o = run_i && sbr_last && osr_last;

  // counters are cleared while idle so each frame starts on a full period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sbr_cnt_q <= '0;
      osr_cnt_q <= '0;
    end else if (!run_i) begin
      sbr_cnt_q <= '0;
      osr_cnt_q <= '0;
    end else if (sbr_last) begin
      sbr_cnt_q <= '0;
      osr_cnt_q <= osr_last ? '0 : osr_cnt_q + OSR_W'(1);
    end else begin
      sbr_cnt_q <= sbr_cnt_q + SBR_W'(1);
    end
  end

  a_r1_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (sbr_cnt_q < sbr_eff) && (osr_cnt_q <= osr_i));
endmodule

// File: rtl/uart_tx_cts_sync.sv
module uart_tx_cts_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] sr_q;

  // reset to 1: clear-to-send treated as deasserted until sampled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[STAGES-2:0], async_i};
  end

  assign sync_o = sr_q[STAGES-1];
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pending_i,
  input  logic              permit_i,
  input  logic [CHAR_W-1:0] data_i,
  input  logic              bit_tick_i,
  output logic              launch_o,
  output logic              run_o,
  output logic              frame_end_o,
  output logic              txd_o
);
  tx_state_e         state_q;
  logic [CHAR_W-1:0] shreg_q;
  logic [IDX_W-1:0]  idx_q;

  assign launch_o    = (state_q == ST_IDLE) && pending_i && permit_i;
  assign run_o       = (state_q != ST_IDLE);
  assign frame_end_o = (state_q == ST_STOP) && bit_tick_i;

  always_comb begin
    unique case (state_q)
      ST_START: txd_o = 1'b0;
      ST_DATA:  txd_o = shreg_q[0];
      default:  txd_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (launch_o) begin
          state_q <= ST_START;
          shreg_q <= data_i;
          idx_q   <= '0;
        end
        ST_START: if (bit_tick_i) state_q <= ST_DATA;
        ST_DATA: if (bit_tick_i) begin
          shreg_q <= shreg_q >> 1;
          idx_q   <= idx_q + IDX_W'(1);
          if (idx_q == IDX_W'(CHAR_W - 1)) state_q <= ST_STOP;
        end
        ST_STOP: if (bit_tick_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r5_bit_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && !bit_tick_i) |=> $stable(txd_o));
endmodule

// File: rtl/uart_cts_tx.sv
module uart_cts_tx
  import uart_tx_pkg::*;
#(
  parameter int unsigned OSR_W = 5,
  parameter int unsigned SBR_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OSR_W-1:0]  osr_i,
  input  logic [SBR_W-1:0]  sbr_i,
  input  logic              cts_en_i,
  input  logic              cts_ni,
  input  logic [CHAR_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              txd_o,
  output logic              tx_done_o
);
  logic              hold_full_q, done_q;
  logic [CHAR_W-1:0] hold_data_q;
  logic              cts_sync, permit, launch, run, frame_end, bit_tick, accept;

  assign tx_ready_o = !hold_full_q;
  assign accept     = tx_valid_i && tx_ready_o;
  assign permit     = !cts_en_i || !cts_sync;
  assign tx_done_o  = done_q;

  uart_tx_cts_sync #(.STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(cts_ni), .sync_o(cts_sync));

  uart_tx_baud_gen #(.OSR_W(OSR_W), .SBR_W(SBR_W)) u_baud (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run),
    .osr_i(osr_i), .sbr_i(sbr_i), .bit_tick_o(bit_tick));

  uart_tx_shifter u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .pending_i(hold_full_q), .permit_i(permit),
    .data_i(hold_data_q), .bit_tick_i(bit_tick), .launch_o(launch), .run_o(run),
    .frame_end_o(frame_end), .txd_o(txd_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_full_q <= 1'b0;
      hold_data_q <= '0;
      done_q      <= 1'b1;
    end else begin
      if (accept) begin
        hold_full_q <= 1'b1;
        hold_data_q <= tx_data_i;
      end else if (launch) begin
        hold_full_q <= 1'b0;
      end
      if (accept)                         done_q <= 1'b0;
      else if (frame_end && !hold_full_q) done_q <= 1'b1;
    end
  end

  a_r3_ready_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && tx_ready_o) |=> !tx_ready_o);
  a_r4_cts_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && cts_en_i && cts_sync) |=> txd_o);
  a_r7_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |-> txd_o);
endmodule

// File: tb/uart_cts_tx_bench.sv
module uart_cts_tx_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic [4:0]  osr = 5'd3;
  logic [12:0] sbr = 13'd2;
  logic        cts_en = 0, cts_n = 1;
  logic [7:0]  tx_data = 0;
  logic        tx_valid = 0;
  logic        tx_ready, txd, tx_done;

  int tests = 0, fails = 0, frames = 0;
  int bit_p = 8;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_cts_tx u_uart_cts_tx (
    .clk_i(clk), .rst_ni(rst_n), .osr_i(osr), .sbr_i(sbr), .cts_en_i(cts_en),
    .cts_ni(cts_n), .tx_data_i(tx_data), .tx_valid_i(tx_valid),
    .tx_ready_o(tx_ready), .txd_o(txd), .tx_done_o(tx_done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data = b; tx_valid = 1; exp_q.push_back(b);
    @(negedge clk);
    chk(!tx_ready, "R3 ready low after accept", tx_ready, 0);
    tx_valid = 0;
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (!tx_done) @(negedge clk);
  endtask

  task automatic wait_fall();
    @(negedge clk);
    while (txd) @(negedge clk);
  endtask

  // monitor: decodes frames at mid-bit and compares against the queue (R2)
  initial begin
    logic [7:0] got;
    logic prev;
    prev = 1;
    forever begin
      @(negedge clk);
      if (rst_n && prev && !txd) begin
        repeat (bit_p/2) @(negedge clk);
        chk(txd == 0, "R2 start bit low", txd, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (bit_p) @(negedge clk);
          got[i] = txd;
        end
        repeat (bit_p) @(negedge clk);
        chk(txd == 1, "R2 stop bit high", txd, 1);
        if (exp_q.size() == 0) chk(0, "R2 unexpected frame", got, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(got == e, "R2 frame data LSB first", got, e);
        end
        frames++;
      end
      prev = txd;
    end
  end

  task automatic measure_start(input int exp_len, input string req);
    int n;
    wait_fall();
    n = 0;
    while (!txd) begin n++; @(negedge clk); end
    chk(n == exp_len, req, n, exp_len);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; tests++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int f0, lows;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(txd == 1, "R8 txd idle after reset", txd, 1);
    chk(tx_ready == 1, "R8 ready after reset", tx_ready, 1);
    chk(tx_done == 1, "R8 done after reset", tx_done, 1);

    // R1 + R2 with P=8, gating off, cts deasserted (R6)
    fork
      send(8'h55);
      measure_start(8, "R1 start length osr=3 sbr=2");
    join
    chk(tx_done == 0, "R7 done low while sending", tx_done, 0);
    wait_done();
    send(8'hA5); wait_done();
    send(8'h00); wait_done();
    send(8'hFF); send(8'h3C); wait_done();
    chk(frames == 5, "R6 frames sent with cts off", frames, 5);
    chk(txd == 1, "R7 txd high when done", txd, 1);

    // R1 at 48-cycle bit: osr=15 sbr=3
    osr = 5'd15; sbr = 13'd3; bit_p = 48;
    fork
      send(8'h01);
      measure_start(48, "R1 start length osr=15 sbr=3");
    join
    wait_done();

    // R4: gating on, cts deasserted holds the character
    osr = 5'd3; sbr = 13'd2; bit_p = 8;
    cts_en = 1; cts_n = 1;
    f0 = frames;
    send(8'h96);
    lows = 0;
    repeat (300) begin @(negedge clk); if (!txd) lows++; end
    chk(lows == 0, "R4 txd held at mark", lows, 0);
    chk(frames == f0, "R4 no frame while blocked", frames, f0);
    chk(tx_done == 0, "R7 done low while pending", tx_done, 0);
    chk(tx_ready == 0, "R4 character kept", tx_ready, 0);
    cts_n = 0;
    wait_done();
    chk(frames == f0 + 1, "R4 sent after cts low", frames, f0 + 1);

    // R5: cts deasserted mid-frame, second char waits
    f0 = frames;
    send(8'hC3);
    wait_fall();
    repeat (3 * 8) @(negedge clk);
    cts_n = 1;
    send(8'h81);
    repeat (12 * 8) @(negedge clk);
    chk(frames == f0 + 1, "R5 first frame completed", frames, f0 + 1);
    lows = 0;
    repeat (200) begin @(negedge clk); if (!txd) lows++; end
    chk(lows == 0, "R5 next frame waits for cts", lows, 0);
    chk(tx_done == 0, "R7 done low with pending char", tx_done, 0);
    cts_n = 0;
    wait_done();
    chk(frames == f0 + 2, "R5 second frame after release", frames, f0 + 2);

    // R6 again: gating off overrides deasserted cts
    cts_en = 0; cts_n = 1;
    send(8'h7E); wait_done();
    chk(frames == f0 + 3, "R6 send with gating disabled", frames, f0 + 3);
    chk(exp_q.size() == 0, "R2 all frames observed", exp_q.size(), 0);

    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule